// File: doc/BRIEF.md
# Synchronous Burst SRAM Cycle Controller

This block sits in front of a synchronous burst static RAM array. On every rising clock edge it looks at three chip enables, two address strobes, a burst-advance input, the write-enable group and a sleep input. From these it picks one cycle type: deselect, sleep, begin read burst, begin write burst, advance burst, hold burst, or a no-operation when a burst command arrives with no burst open. It keeps the base address and a two-bit linear burst counter, and it presents the beat address, the write strobe and the data-bus drive enable to the array and pad logic.

There are two address strobes. The processor-side strobe always opens a read. It is ignored whenever the primary enable is inactive. The controller-side strobe can open either a read or a write. When neither strobe acts, the advance input moves the burst address forward or freezes it. The output enable acts on the drive enable directly and is never sampled by the clock. When the drive enable is low, the data bus is at high impedance.

Top module: `sbsram_ctrl`

## Requirements
- R1: The `cycle` output shows the decision for the coming edge with these codes: 0 deselect, 1 sleep, 2 begin read, 3 begin write, 4 advance, 5 hold, 6 no-op. When `sleep` is high the code is 1 whatever the other inputs are. After that edge the burst is closed: a later advance request gives code 6, and `wr_strobe` and `dq_oe` are 0.
- R2: The cycle is a deselect (code 0) when `ce_main_n`=1 with `ads_ctl_n`=0. It is also a deselect when a strobe is accepted with `ce_aux`=0 or `ce_aux_n`=1. After a deselect edge, `wr_strobe` and `dq_oe` are 0 and the burst is closed.
- R3: With `ce_main_n`=0, `ce_aux`=1, `ce_aux_n`=0 and `ads_cpu_n`=0, the cycle is a begin read (code 2), whatever the write inputs are. After the edge `addr_out` equals `addr_ext`.
- R4: With `ads_cpu_n`=1, `ads_ctl_n`=0 and all enables active, the cycle is a begin write (code 3) when the combined write is active, and a begin read (code 2) otherwise. After the edge `addr_out` equals `addr_ext`.
- R5: The combined write is active when `gw_n`=0, or when `bwe_n`=0 and at least one bit of `bw_n` is 0. It is inactive otherwise. After an edge that starts or continues a write beat, `wr_strobe`=1.
- R6: When no strobe is accepted and a burst is open, `adv_n`=0 gives code 4 and the low two address bits step by +1 modulo 4, with the upper bits kept. `adv_n`=1 gives code 5 and the address stays the same. Both codes accept a read or a write beat.
- R7: While `ce_main_n`=1, `ads_cpu_n` has no effect. The cycle is decided by `ads_ctl_n` and `adv_n` alone.
- R8: An advance or hold request with no burst open gives code 6. After that edge `wr_strobe` and `dq_oe` are 0.
- R9: `dq_oe` is 1 only during a read beat with `oe_n`=0. It follows `oe_n` with no clock edge in between, and it is 0 during write beats.
- R10: A synchronous active-high `rst` clears the burst state: `addr_out`=0, `wr_strobe`=0, `dq_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_main_n | input | 1 | Primary chip enable, active low |
| ce_aux | input | 1 | Secondary chip enable, active high |
| ce_aux_n | input | 1 | Secondary chip enable, active low |
| ads_cpu_n | input | 1 | Processor-side address strobe, active low |
| ads_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | NB | Per-byte write enables, active low |
| sleep | input | 1 | Sleep request, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr_ext | input | AW | External address |
| addr_out | output | AW | Address of the current beat |
| wr_strobe | output | 1 | Current beat is a write |
| dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| cycle | output | 3 | Cycle type decoded for the coming edge |

## Verification
The bench opens a burst whose low address bits start at 2. A counter that adds without wrapping into the base low bits would then carry into bit 2, and the hold cycle would catch a design that steps anyway. It sets the processor strobe active while the primary enable is high, which a design that honours that strobe would turn into a new read. It also issues advance requests just after a deselect and just after a sleep, where a design that forgets to close the burst would drive the bus. The bench gives the controller-side strobe byte-write enable with every byte disabled, which a loose write decode would treat as a write. It toggles the output enable between edges to show that the drive enable follows it with no register in the path.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
    typedef enum logic [2:0] {
        CYC_DESEL    = 3'd0,
        CYC_SLEEP    = 3'd1,
        CYC_RD_BEGIN = 3'd2,
        CYC_WR_BEGIN = 3'd3,
        CYC_ADVANCE  = 3'd4,
        CYC_HOLD     = 3'd5,
        CYC_NOP      = 3'd6
    } cyc_e;
endpackage

// File: rtl/sbsram_wrdec.sv
module sbsram_wrdec #(
    parameter int NB = 4
) (
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    output logic          wr_any
);
    logic byte_sel;

    always_comb begin
        byte_sel = 1'b0;
        for (int i = 0; i < NB; i++) begin
            byte_sel = byte_sel | ~bw_n[i];
        end
        wr_any = ~gw_n | (~bwe_n & byte_sel);
    end

    always_comb begin
        if (gw_n && bwe_n) begin
            AST_IDLE_GROUP_NO_WRITE: assert (!wr_any); // R5
        end
    end
endmodule

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
(
    input  logic sleep,
    input  logic ce_main_n,
    input  logic ce_aux,
    input  logic ce_aux_n,
    input  logic ads_cpu_n,
    input  logic ads_ctl_n,
    input  logic adv_n,
    input  logic wr_any,
    input  logic burst_open,
    output cyc_e cyc
);
    logic aux_ok;
    cyc_e burst_cmd;

    always_comb begin
        aux_ok    = ce_aux & ~ce_aux_n;
        burst_cmd = burst_open ? (adv_n ? CYC_HOLD : CYC_ADVANCE) : CYC_NOP;
        if (sleep) begin
            cyc = CYC_SLEEP;
        end else if (ce_main_n) begin
            cyc = ads_ctl_n ? burst_cmd : CYC_DESEL;
        end else if (!ads_cpu_n) begin
            cyc = aux_ok ? CYC_RD_BEGIN : CYC_DESEL;
        end else if (!ads_ctl_n) begin
            if (!aux_ok)     cyc = CYC_DESEL;
            else if (wr_any) cyc = CYC_WR_BEGIN;
            else             cyc = CYC_RD_BEGIN;
        end else begin
            cyc = burst_cmd;
        end
    end

    always_comb begin
        if (ce_main_n && !sleep) begin
            AST_CPU_STROBE_IGNORED: assert (cyc != CYC_RD_BEGIN && cyc != CYC_WR_BEGIN); // R7
        end
    end
endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int AW        = 8,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  cyc_e          cyc,
    input  logic          wr_any,
    input  logic [AW-1:0] addr_ext,
    output logic [AW-1:0] addr_out,
    output logic          wr_beat,
    output logic          rd_beat,
    output logic          burst_open
);
    localparam int CW = $clog2(BURST_LEN);

    typedef struct packed {
        logic          open;
        logic          rd;
        logic          wr;
        logic [AW-1:0] base;
        logic [CW-1:0] cnt;
    } burst_t;

    burst_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (cyc)
            CYC_RD_BEGIN, CYC_WR_BEGIN: begin
                s_d.open = 1'b1;
                s_d.rd   = (cyc == CYC_RD_BEGIN);
                s_d.wr   = (cyc == CYC_WR_BEGIN);
                s_d.base = addr_ext;
                s_d.cnt  = '0;
            end
            CYC_ADVANCE: begin
                s_d.cnt = s_q.cnt + 1'b1;
                s_d.rd  = ~wr_any;
                s_d.wr  = wr_any;
            end
            CYC_HOLD: begin
                s_d.rd = ~wr_any;
                s_d.wr = wr_any;
            end
            CYC_NOP: begin
                s_d.rd = 1'b0;
                s_d.wr = 1'b0;
            end
            default: begin
                s_d.open = 1'b0;
                s_d.rd   = 1'b0;
                s_d.wr   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    logic [CW-1:0] lo_q;
    always_comb begin
        lo_q     = s_q.base[CW-1:0] + s_q.cnt;
        addr_out = {s_q.base[AW-1:CW], lo_q};
    end

    assign wr_beat    = s_q.wr;
    assign rd_beat    = s_q.rd;
    assign burst_open = s_q.open;

    AST_BEGIN_TAKES_EXT: assert property (@(posedge clk) disable iff (rst)
        (cyc == CYC_RD_BEGIN || cyc == CYC_WR_BEGIN) |=> (addr_out == $past(addr_ext))); // R3
    AST_ADVANCE_STEPS: assert property (@(posedge clk) disable iff (rst)
        (cyc == CYC_ADVANCE) |=> (addr_out[CW-1:0] == CW'($past(addr_out[CW-1:0]) + 1'b1))
                                 && (addr_out[AW-1:CW] == $past(addr_out[AW-1:CW]))); // R6
    AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
        (cyc == CYC_HOLD) |=> $stable(addr_out)); // R6
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cyc == CYC_NOP) |=> (!wr_beat && !rd_beat)); // R8
    AST_SLEEP_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (cyc == CYC_SLEEP) |=> !burst_open); // R1
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int AW        = 8,
    parameter int NB        = 4,
    parameter int BURST_LEN = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_main_n,
    input  logic          ce_aux,
    input  logic          ce_aux_n,
    input  logic          ads_cpu_n,
    input  logic          ads_ctl_n,
    input  logic          adv_n,
    input  logic          gw_n,
    input  logic          bwe_n,
    input  logic [NB-1:0] bw_n,
    input  logic          sleep,
    input  logic          oe_n,
    input  logic [AW-1:0] addr_ext,
    output logic [AW-1:0] addr_out,
    output logic          wr_strobe,
    output logic          dq_oe,
    output logic [2:0]    cycle
);
    logic wr_any;
    logic burst_open;
    logic rd_beat;
    cyc_e cyc;

    sbsram_wrdec #(.NB(NB)) wrdec_i (
        .gw_n   (gw_n),
        .bwe_n  (bwe_n),
        .bw_n   (bw_n),
        .wr_any (wr_any)
    );

    sbsram_decode decode_i (
        .sleep      (sleep),
        .ce_main_n  (ce_main_n),
        .ce_aux     (ce_aux),
        .ce_aux_n   (ce_aux_n),
        .ads_cpu_n  (ads_cpu_n),
        .ads_ctl_n  (ads_ctl_n),
        .adv_n      (adv_n),
        .wr_any     (wr_any),
        .burst_open (burst_open),
        .cyc        (cyc)
    );

    sbsram_burst #(.AW(AW), .BURST_LEN(BURST_LEN)) burst_i (
        .clk        (clk),
        .rst        (rst),
        .cyc        (cyc),
        .wr_any     (wr_any),
        .addr_ext   (addr_ext),
        .addr_out   (addr_out),
        .wr_beat    (wr_strobe),
        .rd_beat    (rd_beat),
        .burst_open (burst_open)
    );

    assign dq_oe = rd_beat & ~oe_n & ~wr_strobe;
    assign cycle = cyc;

    AST_DESEL_DARK: assert property (@(posedge clk) disable iff (rst)
        (cyc == CYC_DESEL) |=> (!dq_oe && !wr_strobe)); // R2
endmodule

// File: tb/sbsram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sbsram_ctrl_tb_top;
    localparam int AW = 8;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_main_n = 1'b1, ce_aux = 1'b1, ce_aux_n = 1'b0;
    logic ads_cpu_n = 1'b1, ads_ctl_n = 1'b1, adv_n = 1'b1;
    logic gw_n = 1'b1, bwe_n = 1'b1, sleep = 1'b0, oe_n = 1'b0;
    logic [NB-1:0] bw_n = '1;
    logic [AW-1:0] addr_ext = '0;
    logic [AW-1:0] addr_out;
    logic wr_strobe, dq_oe;
    logic [2:0] cycle;

    always #2 clk = ~clk;

    sbsram_ctrl #(.AW(AW), .NB(NB), .BURST_LEN(4)) dut_i (
        .clk(clk), .rst(rst), .ce_main_n(ce_main_n), .ce_aux(ce_aux), .ce_aux_n(ce_aux_n),
        .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .sleep(sleep), .oe_n(oe_n), .addr_ext(addr_ext),
        .addr_out(addr_out), .wr_strobe(wr_strobe), .dq_oe(dq_oe), .cycle(cycle)
    );

    int n_checks = 0;
    int n_errors = 0;

    typedef struct {
        string         tag;
        logic [AW-1:0] a;
        logic          w;
        logic          d;
    } exp_t;
    exp_t sb_q[$];

    logic          m_open = 1'b0, m_rd = 1'b0, m_wr = 1'b0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one clock of inputs; exp_cyc is the cycle code the requirements call for.
    task automatic step(input string tag, input logic pn, input logic sh, input logic sn,
                        input logic cpu, input logic ctl, input logic adv, input logic gw,
                        input logic bwe, input logic [NB-1:0] bw, input logic slp,
                        input logic [AW-1:0] ext, input logic [2:0] exp_cyc);
        logic  wr;
        exp_t  e;
        @(negedge clk);
        ce_main_n = pn; ce_aux = sh; ce_aux_n = sn; ads_cpu_n = cpu; ads_ctl_n = ctl;
        adv_n = adv; gw_n = gw; bwe_n = bwe; bw_n = bw; sleep = slp; addr_ext = ext;
        #1;
        check({tag, " cycle"}, 32'(cycle), 32'(exp_cyc));
        wr = !gw || (!bwe && bw != '1);
        case (exp_cyc)
            3'd2, 3'd3: begin
                m_open = 1'b1; m_rd = (exp_cyc == 3'd2); m_wr = (exp_cyc == 3'd3);
                m_base = ext; m_cnt = 2'd0;
            end
            3'd4: begin m_cnt = m_cnt + 2'd1; m_rd = !wr; m_wr = wr; end
            3'd5: begin m_rd = !wr; m_wr = wr; end
            3'd6: begin m_rd = 1'b0; m_wr = 1'b0; end
            default: begin m_open = 1'b0; m_rd = 1'b0; m_wr = 1'b0; end
        endcase
        e.tag = tag;
        e.a   = {m_base[AW-1:2], m_base[1:0] + m_cnt};
        e.w   = m_wr;
        e.d   = m_rd && !m_wr;
        sb_q.push_back(e);
    endtask

    // Monitor: compares beat outputs one ns after each edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                check({e.tag, " addr_out"}, 32'(addr_out), 32'(e.a));
                check({e.tag, " wr_strobe"}, 32'(wr_strobe), 32'(e.w));
                check({e.tag, " dq_oe"}, 32'(dq_oe), 32'(e.d));
            end
        end
    end

    initial begin
        #(200000 * 4);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset addr_out", 32'(addr_out), 32'h0);
        check("R10 reset wr_strobe", 32'(wr_strobe), 32'h0);
        check("R10 reset dq_oe", 32'(dq_oe), 32'h0);
        rst = 1'b0;

        //    tag                    pn sh sn cpu ctl adv gw bwe bw      slp ext    cyc
        step("R8 nop after reset",   1, 1, 0, 1,  1,  0,  1, 1,  4'hF,   0, 8'h00, 3'd6);
        step("R3 cpu read gw low",   0, 1, 0, 0,  1,  1,  0, 1,  4'hF,   0, 8'h5E, 3'd2);
        step("R7 cpu ignored adv",   1, 1, 0, 0,  1,  0,  1, 1,  4'hF,   0, 8'hA0, 3'd4);
        step("R6 advance wrap",      0, 1, 0, 1,  1,  0,  1, 1,  4'hF,   0, 8'h00, 3'd4);
        step("R6 advance",           0, 1, 0, 1,  1,  0,  1, 1,  4'hF,   0, 8'h00, 3'd4);
        step("R6 hold",              0, 1, 0, 1,  1,  1,  1, 1,  4'hF,   0, 8'h00, 3'd5);
        oe_n = 1'b1;
        #0.2;
        check("R9 oe_n high dark", 32'(dq_oe), 32'h0);
        oe_n = 1'b0;
        #0.2;
        check("R9 oe_n low drives", 32'(dq_oe), 32'h1);
        step("R5 advance byte write",0, 1, 0, 1,  1,  0,  1, 0,  4'b1101, 0, 8'h00, 3'd4);
        step("R9 hold gw write",     0, 1, 0, 1,  1,  1,  0, 1,  4'hF,   0, 8'h00, 3'd5);
        step("R2 deselect main",     1, 1, 0, 1,  0,  0,  1, 1,  4'hF,   0, 8'h00, 3'd0);
        step("R8 nop after desel",   1, 1, 0, 1,  1,  0,  1, 1,  4'hF,   0, 8'h00, 3'd6);
        step("R4 ctl write begin",   0, 1, 0, 1,  0,  1,  1, 0,  4'b1110, 0, 8'h33, 3'd3);
        step("R4 R5 ctl no bytes",   0, 1, 0, 1,  0,  1,  1, 0,  4'hF,   0, 8'h40, 3'd2);
        step("R2 aux_n inactive",    0, 1, 1, 0,  1,  1,  1, 1,  4'hF,   0, 8'h55, 3'd0);
        step("R3 cpu read",          0, 1, 0, 0,  1,  1,  1, 1,  4'hF,   0, 8'h81, 3'd2);
        step("R2 aux inactive",      0, 0, 0, 0,  1,  1,  1, 1,  4'hF,   0, 8'h82, 3'd0);
        step("R3 cpu read again",    0, 1, 0, 0,  1,  1,  1, 1,  4'hF,   0, 8'h90, 3'd2);
        step("R1 sleep overrides",   0, 1, 0, 0,  0,  0,  0, 0,  4'h0,   1, 8'h12, 3'd1);
        step("R1 closed after sleep",1, 1, 0, 1,  1,  0,  1, 1,  4'hF,   0, 8'h00, 3'd6);
        step("R3 read despite writes",0,1, 0, 0,  1,  1,  0, 0,  4'h0,   0, 8'hA7, 3'd2);
        step("R6 advance from A7",   0, 1, 0, 1,  1,  0,  1, 1,  4'hF,   0, 8'h00, 3'd4);

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule